// File: doc/BRIEF.md
# BCD Calendar Counter with Century Flag

This block holds wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours in 24-hour form, day of month, weekday, month and a two-digit year, plus a century flag kept in bit 7 of the month field. A prescaler counts enable pulses from a 32.768 kHz reference and produces one advance per second. Each advance ripples through the fields in a single clock cycle. The day-of-month limit follows the month, and February takes a 29th day whenever the year is a multiple of four.

Three controls shape how the count runs. A stop input clears the prescaler and holds it at zero, so software can release stop and know exactly when the first second ends. A freeze input holds every field steady while an external bus access reads or writes them. A second that ends during freeze is remembered and applied once freeze drops. A load strobe writes every field at once, and it discards any advance that was pending or arriving in the same cycle.

Top module: `cal_bcd_clock`

## Requirements
- R1: All fields are packed BCD (tens digit in bits 7:4, units in bits 3:0). Seconds and minutes count 00–59 and hours count 00–23. Moving from 23:59:59 gives 00:00:00 and advances the date, and every digit carry, such as 09:59:59 to 10:00:00, lands in the same cycle.
- R2: The seconds field advances once for every PRESC_DIV cycles in which ref_en is high. Cycles with ref_en low do not count.
- R3: Day of month runs from 01 up to 30 in months 04, 06, 09 and 11, up to 31 in every month except 02, and then returns to 01 while the month advances. Month 12 wraps to 01 and the year advances.
- R4: February ends after day 29 when the year value is a multiple of four, year 00 included, and after day 28 otherwise.
- R5: When the year moves from 99 to 00, bit 7 of the month output (the century flag) toggles. The month digits in bits 4:0 read 01 afterwards.
- R6: The weekday (3 bits) advances by one on every day change and wraps from 6 to 0.
- R7: While stop is high the prescaler is held at zero and no field changes. After stop falls, the first advance comes after exactly PRESC_DIV further ref_en cycles.
- R8: While freeze is high no field changes. A second that ends during freeze is applied exactly once, in the first cycle after freeze falls.
- R9: A cycle with ld_en high writes every field, the month's century bit included, and the values appear in the next cycle. An advance that was pending, or that arrives in that cycle, is dropped.
- R10: After reset the fields read 00:00:00, day 01, weekday 0, month 01 with the century flag clear, and year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One pulse per 32.768 kHz reference period |
| stop | input | 1 | Clear and hold the prescaler |
| freeze | input | 1 | Hold all fields during an external access |
| ld_en | input | 1 | Write all fields from the ld_* inputs |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_day | input | 8 | BCD day of month to load |
| ld_wday | input | 3 | Weekday to load (0–6) |
| ld_month | input | 8 | Century flag in bit 7, BCD month in bits 4:0 |
| ld_year | input | 8 | BCD year to load |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| day_o | output | 8 | BCD day of month |
| wday_o | output | 3 | Weekday |
| month_o | output | 8 | Century flag in bit 7, BCD month in bits 4:0 |
| year_o | output | 8 | BCD year |

## Verification
The bench loads the last second of particular days and checks the next date. These days cover 30- and 31-day months, February in years 23, 24 and 00, and both the 99-to-00 year wrap and the weekday wrap. A wrong month-length table or a leap rule that skipped year 00 would land on the wrong day, and a missed BCD carry would show a value such as 0x0A. Stop is raised part-way through a second, and the bench counts reference pulses after release, which exposes a prescaler that keeps its old count. Freeze and load are applied over a second boundary, which catches a second that is lost, applied twice, or carried into freshly loaded values.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned BCD_W = 8;

  typedef logic [BCD_W-1:0] bcd8_t;

  localparam bcd8_t SEC_LAST  = 8'h59;
  localparam bcd8_t HOUR_LAST = 8'h23;
  localparam bcd8_t YEAR_LAST = 8'h99;
  localparam logic [4:0] MON_LAST = 5'h12;
  localparam logic [2:0] WDAY_LAST = 3'd6;

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_is_leap(input bcd8_t y);
    logic [7:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    year_is_leap = (bin[1:0] == 2'b00);
  endfunction

  function automatic bcd8_t month_last_day(input logic [4:0] m, input bcd8_t y);
    case (m)
      5'h02:                      month_last_day = year_is_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_last_day = 8'h30;
      default:                    month_last_day = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned PRESC_DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  input  logic stop,
  output logic sec_pulse
);
  localparam int unsigned CNT_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESC_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      cnt_q     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= 1'b0;
      if (ref_en) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q     <= '0;
          sec_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: stop leaves the divider at zero with no pulse in flight
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (rst)
    stop |=> (cnt_q == '0) && !sec_pulse);

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  ld,
  input  bcd8_t ld_sec,
  input  bcd8_t ld_min,
  input  bcd8_t ld_hour,
  output bcd8_t sec_q,
  output bcd8_t min_q,
  output bcd8_t hour_q,
  output logic  day_carry
);
  logic sec_wrap, min_wrap, hour_wrap;

  assign sec_wrap  = (sec_q == SEC_LAST);
  assign min_wrap  = (min_q == SEC_LAST);
  assign hour_wrap = (hour_q == HOUR_LAST);
  assign day_carry = adv && !ld && sec_wrap && min_wrap && hour_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else if (ld) begin
      sec_q  <= ld_sec;
      min_q  <= ld_min;
      hour_q <= ld_hour;
    end else if (adv) begin
      sec_q <= sec_wrap ? '0 : bcd_inc(sec_q);
      if (sec_wrap) begin
        min_q <= min_wrap ? '0 : bcd_inc(min_q);
        if (min_wrap) hour_q <= hour_wrap ? '0 : bcd_inc(hour_q);
      end
    end
  end

  // R1: hours stay within 00..23 as valid BCD
  assert_hour_range_R1: assert property (@(posedge clk) disable iff (rst || ld)
    !ld |=> (hour_q[3:0] <= 4'd9) && (hour_q <= HOUR_LAST));

endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_adv,
  input  logic       ld,
  input  bcd8_t      ld_day,
  input  logic [2:0] ld_wday,
  input  bcd8_t      ld_month,
  input  bcd8_t      ld_year,
  output bcd8_t      day_q,
  output logic [2:0] wday_q,
  output bcd8_t      month_q,
  output bcd8_t      year_q
);
  logic month_end, year_end, cent_end;

  assign month_end = (day_q == month_last_day(month_q[4:0], year_q));
  assign year_end  = month_end && (month_q[4:0] == MON_LAST);
  assign cent_end  = year_end && (year_q == YEAR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      day_q   <= 8'h01;
      wday_q  <= '0;
      month_q <= 8'h01;
      year_q  <= '0;
    end else if (ld) begin
      day_q   <= ld_day;
      wday_q  <= ld_wday;
      month_q <= ld_month;
      year_q  <= ld_year;
    end else if (day_adv) begin
      wday_q <= (wday_q == WDAY_LAST) ? '0 : wday_q + 3'd1;
      day_q  <= month_end ? 8'h01 : bcd_inc(day_q);
      if (month_end) begin
        month_q[4:0] <= year_end ? 5'h01 : 5'(bcd_inc({3'b000, month_q[4:0]}));
        if (year_end) begin
          year_q <= cent_end ? '0 : bcd_inc(year_q);
          if (cent_end) month_q[7] <= ~month_q[7];
        end
      end
    end
  end

  // R6: weekday never leaves 0..6 once running from a valid value
  assert_wday_range_R6: assert property (@(posedge clk) disable iff (rst)
    (wday_q <= WDAY_LAST) && !ld |=> (wday_q <= WDAY_LAST));

  // R5: the century flag only changes when the year has just become 00
  assert_century_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(month_q[7]) && !$past(ld)) |-> (year_q == 8'h00));

endmodule

// File: rtl/cal_bcd_clock.sv
module cal_bcd_clock
  import cal_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_en,
  input  logic       stop,
  input  logic       freeze,
  input  logic       ld_en,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_day,
  input  logic [2:0] ld_wday,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [2:0] wday_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic sec_pulse, pend_q, adv, day_carry;

  cal_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst(rst), .ref_en(ref_en), .stop(stop), .sec_pulse(sec_pulse)
  );

  // a second that ends under freeze is held here until freeze falls
  always_ff @(posedge clk) begin
    if (rst || stop || ld_en) pend_q <= 1'b0;
    else if (freeze)          pend_q <= pend_q || sec_pulse;
    else                      pend_q <= pend_q && sec_pulse;
  end

  assign adv = !freeze && !ld_en && (sec_pulse || pend_q);

  cal_time_chain u_time (
    .clk(clk), .rst(rst), .adv(adv), .ld(ld_en),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o), .day_carry(day_carry)
  );

  cal_date_chain u_date (
    .clk(clk), .rst(rst), .day_adv(day_carry), .ld(ld_en),
    .ld_day(ld_day), .ld_wday(ld_wday), .ld_month(ld_month), .ld_year(ld_year),
    .day_q(day_o), .wday_q(wday_o), .month_q(month_o), .year_q(year_o)
  );

  // R8: nothing moves while frozen
  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (freeze && !ld_en) |=> $stable(sec_o) && $stable(min_o) && $stable(day_o) && $stable(year_o));

  // R9: a load lands whole in the next cycle
  assert_load_exact_R9: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (sec_o == $past(ld_sec)) && (hour_o == $past(ld_hour)) && (month_o == $past(ld_month)));

  // R7: a held stop freezes the seconds field
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stop && $past(stop) && !ld_en) |=> $stable(sec_o));

endmodule

// File: tb/test_cal_bcd_clock.sv
module test_cal_bcd_clock;
  localparam int unsigned DIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ref_en = 0, stop = 0, freeze = 0, ld_en = 0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_day = 0, ld_month = 0, ld_year = 0;
  logic [2:0] ld_wday = 0;
  logic [7:0] sec_o, min_o, hour_o, day_o, month_o, year_o;
  logic [2:0] wday_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cal_bcd_clock #(.PRESC_DIV(DIV)) i_cal_bcd_clock (
    .clk(clk), .rst(rst), .ref_en(ref_en), .stop(stop), .freeze(freeze), .ld_en(ld_en),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_day(ld_day),
    .ld_wday(ld_wday), .ld_month(ld_month), .ld_year(ld_year),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .wday_o(wday_o), .month_o(month_o), .year_o(year_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] snap();
    return {3'b0, wday_o, day_o, month_o, year_o, hour_o, min_o, sec_o, 2'b0};
  endfunction

  function automatic logic [63:0] pack(input logic [7:0] s, m, h, d, input logic [2:0] w,
                                       input logic [7:0] mo, y);
    return {3'b0, w, d, mo, y, h, m, s, 2'b0};
  endfunction

  task automatic ref_pulses(input int n);
    ref_en = 1;
    repeat (n) @(negedge clk);
    ref_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] s, m, h, d, input logic [2:0] w, input logic [7:0] mo, y);
    stop = 1; @(negedge clk); stop = 0;
    ld_sec = s; ld_min = m; ld_hour = h; ld_day = d; ld_wday = w; ld_month = mo; ld_year = y;
    ld_en = 1; @(negedge clk); ld_en = 0;
  endtask

  task automatic roll(input string req, input logic [7:0] s, m, h, d, input logic [2:0] w,
                      input logic [7:0] mo, y, input logic [63:0] exp);
    load(s, m, h, d, w, mo, y);
    ref_pulses(DIV);
    chk(req, snap(), exp);
  endtask

  task automatic t_reset();
    chk("R10 reset state", snap(), pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd0, 8'h01, 8'h00));
  endtask

  task automatic t_prescale();
    load(8'h10, 8'h00, 8'h00, 8'h01, 3'd0, 8'h01, 8'h00);
    ref_pulses(DIV - 1);
    repeat (5) @(negedge clk);
    chk("R2 no advance before full count", {56'd0, sec_o}, 64'h10);
    ref_pulses(1);
    chk("R2 advance at full count", {56'd0, sec_o}, 64'h11);
  endtask

  task automatic t_time_carry();
    roll("R1 digit carry 09:59:59", 8'h59, 8'h59, 8'h09, 8'h05, 3'd2, 8'h03, 8'h21,
         pack(8'h00, 8'h00, 8'h10, 8'h05, 3'd2, 8'h03, 8'h21));
    roll("R1 minute carry 12:34:59", 8'h59, 8'h34, 8'h12, 8'h05, 3'd2, 8'h03, 8'h21,
         pack(8'h00, 8'h35, 8'h12, 8'h05, 3'd2, 8'h03, 8'h21));
  endtask

  task automatic t_month_len();
    roll("R3 30-day April, R6 weekday 6->0", 8'h59, 8'h59, 8'h23, 8'h30, 3'd6, 8'h04, 8'h21,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd0, 8'h05, 8'h21));
    roll("R3 31-day January", 8'h59, 8'h59, 8'h23, 8'h31, 3'd3, 8'h01, 8'h21,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd4, 8'h02, 8'h21));
    roll("R3 Nov 30 ends month", 8'h59, 8'h59, 8'h23, 8'h30, 3'd1, 8'h11, 8'h21,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd2, 8'h12, 8'h21));
    roll("R3 July 30 continues", 8'h59, 8'h59, 8'h23, 8'h30, 3'd1, 8'h07, 8'h21,
         pack(8'h00, 8'h00, 8'h00, 8'h31, 3'd2, 8'h07, 8'h21));
    roll("R3 year advance at Dec 31", 8'h59, 8'h59, 8'h23, 8'h31, 3'd5, 8'h12, 8'h39,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd6, 8'h01, 8'h40));
  endtask

  task automatic t_leap();
    roll("R4 Feb 28 non-leap 23", 8'h59, 8'h59, 8'h23, 8'h28, 3'd1, 8'h02, 8'h23,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd2, 8'h03, 8'h23));
    roll("R4 Feb 28 leap 24", 8'h59, 8'h59, 8'h23, 8'h28, 3'd1, 8'h02, 8'h24,
         pack(8'h00, 8'h00, 8'h00, 8'h29, 3'd2, 8'h02, 8'h24));
    roll("R4 Feb 29 leap 24", 8'h59, 8'h59, 8'h23, 8'h29, 3'd1, 8'h02, 8'h24,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd2, 8'h03, 8'h24));
    roll("R4 Feb 28 year 00 leap", 8'h59, 8'h59, 8'h23, 8'h28, 3'd4, 8'h02, 8'h00,
         pack(8'h00, 8'h00, 8'h00, 8'h29, 3'd5, 8'h02, 8'h00));
    roll("R4 Feb 28 year 90 non-leap", 8'h59, 8'h59, 8'h23, 8'h28, 3'd4, 8'h02, 8'h90,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd5, 8'h03, 8'h90));
  endtask

  task automatic t_century();
    roll("R5 century set on 99->00", 8'h59, 8'h59, 8'h23, 8'h31, 3'd2, 8'h12, 8'h99,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd3, 8'h81, 8'h00));
    roll("R5 century clear on 99->00", 8'h59, 8'h59, 8'h23, 8'h31, 3'd2, 8'h92, 8'h99,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd3, 8'h01, 8'h00));
    roll("R5 century kept on 98->99", 8'h59, 8'h59, 8'h23, 8'h31, 3'd2, 8'h92, 8'h98,
         pack(8'h00, 8'h00, 8'h00, 8'h01, 3'd3, 8'h81, 8'h99));
  endtask

  task automatic t_stop();
    load(8'h20, 8'h00, 8'h00, 8'h01, 3'd0, 8'h01, 8'h00);
    ref_pulses(DIV - 1);
    stop = 1;
    ref_pulses(3 * DIV);
    chk("R7 no advance while stopped", {56'd0, sec_o}, 64'h20);
    stop = 0;
    ref_pulses(DIV - 1);
    chk("R7 prescaler restarted from zero", {56'd0, sec_o}, 64'h20);
    ref_pulses(1);
    chk("R7 first second after release", {56'd0, sec_o}, 64'h21);
  endtask

  task automatic t_freeze();
    load(8'h40, 8'h00, 8'h00, 8'h01, 3'd0, 8'h01, 8'h00);
    freeze = 1;
    ref_pulses(DIV);
    repeat (4) @(negedge clk);
    chk("R8 held while frozen", {56'd0, sec_o}, 64'h40);
    freeze = 0;
    @(negedge clk);
    chk("R8 caught up on release", {56'd0, sec_o}, 64'h41);
    repeat (6) @(negedge clk);
    chk("R8 applied only once", {56'd0, sec_o}, 64'h41);
  endtask

  task automatic t_load_drop();
    load(8'h05, 8'h00, 8'h00, 8'h01, 3'd0, 8'h01, 8'h00);
    freeze = 1;
    ref_pulses(DIV);
    ld_sec = 8'h30; ld_min = 8'h20; ld_hour = 8'h10; ld_day = 8'h15;
    ld_wday = 3'd4; ld_month = 8'h86; ld_year = 8'h42;
    ld_en = 1; @(negedge clk); ld_en = 0;
    chk("R9 load lands next cycle", snap(), pack(8'h30, 8'h20, 8'h10, 8'h15, 3'd4, 8'h86, 8'h42));
    freeze = 0;
    repeat (4) @(negedge clk);
    chk("R9 pending second dropped", snap(), pack(8'h30, 8'h20, 8'h10, 8'h15, 3'd4, 8'h86, 8'h42));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_time_carry();
    t_month_len();
    t_leap();
    t_century();
    t_stop();
    t_freeze();
    t_load_drop();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule